// File: doc/BRIEF.md
# Time-Sliced Video/CPU DRAM Slot Arbiter

This block lets a display address generator and a processor share one DRAM whose address pins carry the row and the column in turn. Each microsecond is cut into sixteen master-clock phases. The first twelve give the display two back-to-back byte fetches. The last four belong to the processor. The block drives the two select lines of an external 4:1 address multiplexer and the multiplexed address itself. It also drives the row and column strobes, the write strobe, a processor wait line and the enables of two one-way data buffers.

The display generator presents one word address per microsecond. The lowest byte-address bit is not taken from the generator. The arbiter's own 1 MHz character clock fills that bit, so one display address yields an even byte and then an odd byte. The two bytes come out together as a 16-bit word with a one-cycle valid strobe. A processor access that misses the start of its slot is held off with the wait line until a slot has finished serving it. The 1 MHz processor/display select line is a plain 1 MHz clock, so it can also clock a slow peripheral.

Top module: `vcslot_arb`

## Requirements
- R1: A 16-phase cycle repeats; phase 0 is the first cycle after reset. `mux_cpu` is high in phases 12–15 only. `char_clk` is high in phases 6–11 only.
- R2: Each display fetch has six phases (A: 0–5, B: 6–11), numbered by offset 0–5 within the fetch. `ras_n` is low at offsets 1–4 and `cas_n` is low at offsets 3–4. `mux_col` is high at offsets 2–4. At offsets 0 and 5 all strobes are high. CAS is never low without RAS.
- R3: `dram_addr` follows the select code {`mux_cpu`,`mux_col`}. 00 gives the display row, `vid_addr[15:8]`. 01 gives the display column, {`vid_addr[7:1]`, `char_clk`}. 10 gives the processor row, `cpu_addr[15:8]`. 11 gives the processor column, `cpu_addr[7:0]`. `vid_addr` is taken at the end of phase 15 and used in the next period.
- R4: The fetch-A byte is taken from `dram_rdata` at the end of phase 4 and the fetch-B byte at the end of phase 10. `vid_word` = {B, A}. `vid_valid` is high in phase 11 only.
- R5: A request first present in phase 12 is served in that slot, with `cpu_ready` high throughout. `ras_n` is low in phases 12–15. `mux_col` is high in phases 13–15 and `cas_n` is low in phases 14–15. The transfer ends at the end of phase 15.
- R6: A request raised in phases 0–11 drives `cpu_ready` low from that cycle on. It stays low until phase 15 of the next slot, where it is high.
- R7: A request raised in phases 13–15 gets no service in the current slot. `cpu_ready` stays low until phase 15 of the following slot.
- R8: `buf_rd_en` (read) or `buf_wr_en` (write) is high only during phases 12–15 of a served slot, and never both at once. `we_n` is low only in phases 14–15 of a served write.
- R9: A processor slot with no request in phase 12 leaves `ras_n`, `cas_n` and `we_n` high.
- R10: Reset is synchronous and active low. While it is applied the phase stays at 0, all strobes are high, `vid_valid` is 0 and both buffer enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | synchronous reset, active low |
| vid_addr | input | 15 | display word address, byte-address bits 15:1 |
| char_clk | output | 1 | 1 MHz character clock, also byte-address bit 0 |
| vid_word | output | 16 | fetched byte pair, odd byte high |
| vid_valid | output | 1 | one-cycle strobe per microsecond for vid_word |
| cpu_req | input | 1 | processor memory request, held until served |
| cpu_we | input | 1 | 1 for a write request |
| cpu_addr | input | 16 | processor byte address |
| cpu_ready | output | 1 | low while the processor must wait |
| dram_addr | output | 8 | multiplexed row/column address |
| mux_cpu | output | 1 | multiplexer source select (1 = processor); 1 MHz peripheral clock |
| mux_col | output | 1 | multiplexer half select (1 = column) |
| ras_n | output | 1 | row strobe, active low |
| cas_n | output | 1 | column strobe, active low |
| we_n | output | 1 | write strobe, active low |
| dram_rdata | input | 8 | DRAM read data |
| buf_wr_en | output | 1 | enable for the processor-to-memory buffer |
| buf_rd_en | output | 1 | enable for the memory-to-processor buffer |

## Verification
The bench targets the arrival phase of a processor request. It sends one request in phase 12, one before the slot and ones in phases 13 and 15. A design that served a late request in the current slot would leave it with a half-formed RAS cycle. A design that let an early request through at phase 12 would finish the processor's cycle three phases too soon. The bench also checks that the character clock lands in the column address, so that the even and odd bytes come out in the right halves of the word. It checks that a new display address takes effect only from the next period. Finally it checks that an idle processor slot raises no strobes. A wrong design there would cause a spurious DRAM read or write.

// File: rtl/vcarb_pkg.sv
// Shared constants for the slot arbiter.
// Assumes a 16-phase microsecond built from a 16 MHz master clock.
package vcarb_pkg;
    localparam int PH_W      = 4;                  // phase counter width
    localparam int NPH       = 1 << PH_W;          // phases per microsecond
    localparam int FETCH_LEN = 6;                  // phases per display fetch
    localparam int NFETCH    = 2;                  // display fetches per period
    localparam int CPU_START = NFETCH * FETCH_LEN; // first processor phase
    // offsets inside a display fetch
    localparam int OFF_RAS   = 1;
    localparam int OFF_COL   = 2;
    localparam int OFF_CAS   = 3;
    localparam int OFF_CAP   = 4;                  // last strobe phase, data taken at its end
    // offsets inside the processor slot
    localparam int C_COL     = 1;
    localparam int C_CAS     = 2;

    // multiplexer source code {cpu_sel, col_sel}
    typedef enum logic [1:0] {
        SRC_VROW = 2'b00,
        SRC_VCOL = 2'b01,
        SRC_CROW = 2'b10,
        SRC_CCOL = 2'b11
    } src_e;
endpackage

// File: rtl/vcarb_sched.sv
// Phase scheduler: free-running phase counter and decode of the slot
// plan into strobe and select timing. Assumes clk is the 16 MHz master.
module vcarb_sched
    import vcarb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic              in_cpu,
    output logic              byte_odd,
    output logic              vid_ras,
    output logic              vid_cas,
    output logic              col_phase,
    output logic              cpu_ras,
    output logic              cpu_cas,
    output logic              slot_first,
    output logic              slot_last,
    output logic [NFETCH-1:0] cap
);
    logic [PH_W-1:0] phase_q;

    // advance one phase per master clock, wrapping each microsecond
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    // decode the phase into slot, offset and strobe timing
    always_comb begin
        int ph;
        int fidx;
        int off;
        int coff;
        ph         = int'(phase_q);
        in_cpu     = (ph >= CPU_START);
        fidx       = in_cpu ? 0 : ph / FETCH_LEN;
        off        = ph - fidx * FETCH_LEN;
        coff       = ph - CPU_START;
        byte_odd   = !in_cpu && ((fidx % 2) == 1);
        vid_ras    = !in_cpu && (off >= OFF_RAS) && (off <= OFF_CAP);
        vid_cas    = !in_cpu && (off >= OFF_CAS) && (off <= OFF_CAP);
        col_phase  = in_cpu ? (coff >= C_COL)
                            : ((off >= OFF_COL) && (off <= OFF_CAP));
        cpu_ras    = in_cpu;
        cpu_cas    = in_cpu && (coff >= C_CAS);
        slot_first = (ph == CPU_START);
        slot_last  = (ph == NPH - 1);
    end

    // one capture pulse per display fetch
    for (genvar k = 0; k < NFETCH; k++) begin : g_cap
        assign cap[k] = (int'(phase_q) == k * FETCH_LEN + OFF_CAP);
    end
endmodule

// File: rtl/vcarb_amux.sv
// Four-source row/column address selector. The sources are display row,
// display column, processor row and processor column, picked by the
// two select lines. Assumes both addresses are byte addresses of 2*MUX_W bits.
module vcarb_amux
    import vcarb_pkg::*;
#(
    parameter int MUX_W = 8
) (
    input  logic               cpu_sel,
    input  logic               col_sel,
    input  logic [2*MUX_W-1:0] vaddr,
    input  logic [2*MUX_W-1:0] caddr,
    output logic [MUX_W-1:0]   dram_addr
);
    logic [MUX_W-1:0] src [4];

    // build the four sources: even code = row half, odd code = column half
    for (genvar k = 0; k < 4; k++) begin : g_src
        if (k < 2) begin : g_vid
            assign src[k] = vaddr[(2 - (k % 2)) * MUX_W - 1 -: MUX_W];
        end else begin : g_cpu
            assign src[k] = caddr[(2 - (k % 2)) * MUX_W - 1 -: MUX_W];
        end
    end

    // route the selected source to the DRAM pins
    always_comb begin
        src_e code;
        code      = src_e'({cpu_sel, col_sel});
        dram_addr = src[code];
    end
endmodule

// File: rtl/vcarb_cpu_gate.sv
// Processor slot gate: decides whether the current slot serves the
// request, and drives the wait line and the buffer enables. Assumes the
// requester holds cpu_req, cpu_we and its address until the transfer ends.
module vcarb_cpu_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic in_cpu,
    input  logic slot_first,
    input  logic slot_last,
    input  logic cpu_req,
    input  logic cpu_we,
    output logic taken,
    output logic cpu_ready,
    output logic buf_wr_en,
    output logic buf_rd_en
);
    logic taken_q;
    logic held_q;

    // a slot serves a request that is present at its first phase
    always_comb begin
        taken     = cpu_req && (slot_first || (in_cpu && taken_q));
        cpu_ready = !cpu_req || (taken && (!held_q || slot_last));
        buf_wr_en = taken && cpu_we;
        buf_rd_en = taken && !cpu_we;
    end

    // remember slot ownership and whether the requester was held off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            taken_q <= taken;
            held_q  <= cpu_req && !(slot_last && taken) && (held_q || !taken);
        end
    end
endmodule

// File: rtl/vcarb_vcap.sv
// Display byte capture: takes one byte per fetch on its capture pulse and
// raises a one-cycle valid after the last byte. Assumes fetch k fills
// byte lane k of the word.
module vcarb_vcap #(
    parameter int DATA_W = 8,
    parameter int NF     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NF-1:0]      cap,
    input  logic [DATA_W-1:0]  rdata,
    output logic [NF*DATA_W-1:0] word,
    output logic               valid
);
    for (genvar k = 0; k < NF; k++) begin : g_lane
        logic [DATA_W-1:0] byte_q;
        // hold the byte of fetch k
        always_ff @(posedge clk) begin
            if (!rst_n)      byte_q <= '0;
            else if (cap[k]) byte_q <= rdata;
        end
        assign word[k*DATA_W +: DATA_W] = byte_q;
    end

    // pulse valid for the cycle after the last capture
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= cap[NF-1];
    end
endmodule

// File: rtl/vcslot_arb.sv
// Top of the slot arbiter: display fetches A and B, then one processor
// slot, in each microsecond of a 16 MHz master clock. Assumes vid_addr
// is stable at the end of phase 15 and the DRAM answers within the CAS phases.
module vcslot_arb
    import vcarb_pkg::*;
#(
    parameter int MUX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*MUX_W-1:1]       vid_addr,
    output logic                     char_clk,
    output logic [NFETCH*DATA_W-1:0] vid_word,
    output logic                     vid_valid,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [2*MUX_W-1:0]       cpu_addr,
    output logic                     cpu_ready,
    output logic [MUX_W-1:0]         dram_addr,
    output logic                     mux_cpu,
    output logic                     mux_col,
    output logic                     ras_n,
    output logic                     cas_n,
    output logic                     we_n,
    input  logic [DATA_W-1:0]        dram_rdata,
    output logic                     buf_wr_en,
    output logic                     buf_rd_en
);
    localparam int ADDR_W = 2 * MUX_W;

    logic              in_cpu, byte_odd, vid_ras, vid_cas, col_phase;
    logic              cpu_ras, cpu_cas, slot_first, slot_last, taken;
    logic [NFETCH-1:0] cap;
    logic [ADDR_W-1:1] vid_q;
    logic [ADDR_W-1:0] vbyte;

    vcarb_sched i_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_cpu    (in_cpu),
        .byte_odd  (byte_odd),
        .vid_ras   (vid_ras),
        .vid_cas   (vid_cas),
        .col_phase (col_phase),
        .cpu_ras   (cpu_ras),
        .cpu_cas   (cpu_cas),
        .slot_first(slot_first),
        .slot_last (slot_last),
        .cap       (cap)
    );

    // take the display address once per period, at the end of the processor slot
    always_ff @(posedge clk) begin
        if (!rst_n)         vid_q <= '0;
        else if (slot_last) vid_q <= vid_addr;
    end

    // the character clock stands in for byte-address bit 0
    assign vbyte = {vid_q, byte_odd};

    vcarb_amux #(.MUX_W(MUX_W)) i_amux (
        .cpu_sel  (in_cpu),
        .col_sel  (col_phase),
        .vaddr    (vbyte),
        .caddr    (cpu_addr),
        .dram_addr(dram_addr)
    );

    vcarb_cpu_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_cpu    (in_cpu),
        .slot_first(slot_first),
        .slot_last (slot_last),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .taken     (taken),
        .cpu_ready (cpu_ready),
        .buf_wr_en (buf_wr_en),
        .buf_rd_en (buf_rd_en)
    );

    vcarb_vcap #(.DATA_W(DATA_W), .NF(NFETCH)) i_vcap (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (cap),
        .rdata(dram_rdata),
        .word (vid_word),
        .valid(vid_valid)
    );

    // strobes: display fetches always run, the processor slot only when served
    always_comb begin
        ras_n    = !(vid_ras || (cpu_ras && taken));
        cas_n    = !(vid_cas || (cpu_cas && taken));
        we_n     = !(cpu_cas && taken && cpu_we);
        mux_cpu  = in_cpu;
        mux_col  = col_phase;
        char_clk = byte_odd;
    end
endmodule

// File: rtl/vcslot_arb_chk.sv
// Property checker for the slot arbiter, attached to every instance
// by the bind below. Observes top-level ports only.
module vcslot_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_ready,
    input logic mux_cpu,
    input logic mux_col,
    input logic ras_n,
    input logic cas_n,
    input logic vid_valid,
    input logic buf_wr_en,
    input logic buf_rd_en
);
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_cpu) |=> mux_cpu);                                        // R1
    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);                                                 // R2
    AST_CAS_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |=> !cas_n);                                           // R2
    AST_ROW_AT_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !mux_col);                                         // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |=> !vid_valid);                                          // R4
    AST_WAIT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !mux_cpu) |-> !cpu_ready);                              // R6
    AST_BUF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_wr_en && buf_rd_en));                                         // R8
    AST_BUF_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_cpu |-> (!buf_wr_en && !buf_rd_en));                           // R8
    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mux_cpu) && !cpu_req) |-> ras_n);                            // R9
endmodule

bind vcslot_arb vcslot_arb_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_ready(cpu_ready),
    .mux_cpu  (mux_cpu),
    .mux_col  (mux_col),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .vid_valid(vid_valid),
    .buf_wr_en(buf_wr_en),
    .buf_rd_en(buf_rd_en)
);

// File: tb/test_vcslot_arb.sv
// Directed bench for the slot arbiter: one task per scenario.
module test_vcslot_arb;
    localparam int M  = 8;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*M-1:1]  vid_addr = '0;
    logic            char_clk;
    logic [2*DW-1:0] vid_word;
    logic            vid_valid;
    logic            cpu_req = 1'b0;
    logic            cpu_we = 1'b0;
    logic [2*M-1:0]  cpu_addr = '0;
    logic            cpu_ready;
    logic [M-1:0]    dram_addr;
    logic            mux_cpu, mux_col, ras_n, cas_n, we_n;
    logic [DW-1:0]   dram_rdata;
    logic            buf_wr_en, buf_rd_en;

    int checks = 0;
    int failures = 0;
    int ph = 0;
    logic [M-1:0] row_l = '0;
    bit ras_seen = 1'b0;

    vcslot_arb i_vcslot_arb (
        .clk(clk), .rst_n(rst_n), .vid_addr(vid_addr), .char_clk(char_clk),
        .vid_word(vid_word), .vid_valid(vid_valid), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
        .dram_addr(dram_addr), .mux_cpu(mux_cpu), .mux_col(mux_col),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_rdata(dram_rdata),
        .buf_wr_en(buf_wr_en), .buf_rd_en(buf_rd_en)
    );

    always #2 clk = ~clk;

    // bench's own phase count, from the reset rule
    always @(posedge clk) ph <= (!rst_n) ? 0 : (ph + 1) % 16;

    // DRAM model: row taken when RAS falls, data = row xor column
    always @(negedge clk) begin
        if (!ras_n && !ras_seen) begin
            row_l    = dram_addr;
            ras_seen = 1'b1;
        end else if (ras_n) begin
            ras_seen = 1'b0;
        end
    end
    assign dram_rdata = row_l ^ dram_addr;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_ph(input int p);
        @(negedge clk);
        while (ph != p) @(negedge clk);
    endtask

    // raise a request just after the edge that starts phase p
    task automatic raise_at(input int p, input bit we, input logic [15:0] a);
        wait_ph((p + 15) % 16);
        @(posedge clk);
        #1;
        cpu_req  = 1'b1;
        cpu_we   = we;
        cpu_addr = a;
    endtask

    task automatic drop_after_edge();
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10", "ras_n in reset", ras_n, 1);
        chk("R10", "cas_n in reset", cas_n, 1);
        chk("R10", "we_n in reset", we_n, 1);
        chk("R10", "vid_valid in reset", vid_valid, 0);
        chk("R10", "buffers in reset", {buf_wr_en, buf_rd_en}, 0);
        @(posedge clk);
        chk("R10", "phase held in reset", mux_cpu, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "phase 1 after reset has RAS", ras_n, 0);
    endtask

    // one full period with no request: selects and strobes per phase
    task automatic t_schedule();
        wait_ph(15);
        for (int i = 0; i < 16; i++) begin
            int p, off;
            bit inv;
            @(negedge clk);
            p   = ph;
            inv = (p < 12);
            off = p % 6;
            chk("R1", $sformatf("mux_cpu ph%0d", p), mux_cpu, !inv);
            chk("R1", $sformatf("char_clk ph%0d", p), char_clk, (p >= 6 && p < 12));
            if (inv) begin
                chk("R2", $sformatf("ras_n ph%0d", p), ras_n, !(off >= 1 && off <= 4));
                chk("R2", $sformatf("cas_n ph%0d", p), cas_n, !(off >= 3 && off <= 4));
                chk("R2", $sformatf("mux_col ph%0d", p), mux_col, (off >= 2 && off <= 4));
            end else begin
                chk("R9", $sformatf("idle ras/cas/we ph%0d", p), {ras_n, cas_n, we_n}, 3'b111);
            end
        end
    endtask

    // display address to DRAM pins and captured word
    task automatic t_video(input logic [14:0] va);
        logic [7:0] row, ca, cb;
        row = va[14:7];
        ca  = {va[6:0], 1'b0};
        cb  = {va[6:0], 1'b1};
        wait_ph(13);
        vid_addr = va;
        wait_ph(1);
        chk("R3", "display row", dram_addr, row);
        wait_ph(2);
        chk("R3", "display column A (bit0=0)", dram_addr, ca);
        wait_ph(8);
        chk("R3", "display column B (bit0=1)", dram_addr, cb);
        wait_ph(10);
        chk("R4", "valid low before ph11", vid_valid, 0);
        wait_ph(11);
        chk("R4", "valid in ph11", vid_valid, 1);
        chk("R4", "word {B,A}", vid_word, {row ^ cb, row ^ ca});
        wait_ph(12);
        chk("R4", "valid gone in ph12", vid_valid, 0);
    endtask

    // request present from phase 12: served at once
    task automatic t_cpu_fresh(input bit we, input logic [15:0] a);
        raise_at(12, we, a);
        for (int i = 0; i < 4; i++) begin
            int p;
            if (i > 0) @(negedge clk);
            else @(negedge clk);
            p = ph;
            chk("R5", $sformatf("ready ph%0d", p), cpu_ready, 1);
            chk("R5", $sformatf("ras_n ph%0d", p), ras_n, 0);
            chk("R5", $sformatf("mux_col ph%0d", p), mux_col, (p >= 13));
            chk("R5", $sformatf("cas_n ph%0d", p), cas_n, !(p >= 14));
            chk("R8", $sformatf("buffers ph%0d", p), {buf_wr_en, buf_rd_en}, we ? 2'b10 : 2'b01);
            chk("R8", $sformatf("we_n ph%0d", p), we_n, !(we && p >= 14));
            if (p == 12) chk("R3", "cpu row", dram_addr, a[15:8]);
            if (p == 13) chk("R3", "cpu column", dram_addr, a[7:0]);
        end
        drop_after_edge();
        @(negedge clk);
        chk("R8", "buffers off after transfer", {buf_wr_en, buf_rd_en}, 0);
    endtask

    // request raised outside the slot start: waits for a full served slot
    task automatic t_cpu_wait(input int pa, input string rq);
        bit seen12 = 1'b0;
        bit done = 1'b0;
        raise_at(pa, 1'b0, 16'h3C96);
        for (int i = 0; i < 40 && !done; i++) begin
            bit exp;
            @(negedge clk);
            if (ph == 12) seen12 = 1'b1;
            exp = seen12 && (ph == 15);
            chk(rq, $sformatf("ready ph%0d (raised ph%0d)", ph, pa), cpu_ready, exp);
            chk("R8", $sformatf("read buffer ph%0d (raised ph%0d)", ph, pa), buf_rd_en, seen12);
            if (exp) done = 1'b1;
        end
        chk(rq, $sformatf("transfer completed (raised ph%0d)", pa), done, 1);
        drop_after_edge();
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_schedule();
        t_video(15'h52E1);
        t_video(15'h2D5A);
        t_cpu_fresh(1'b0, 16'hA7C4);
        t_cpu_fresh(1'b1, 16'h1B3E);
        t_cpu_wait(5, "R6");
        t_cpu_wait(0, "R6");
        t_cpu_wait(13, "R7");
        t_cpu_wait(15, "R7");
        t_schedule();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule